// File: doc/BRIEF.md
# Velocity Threshold Mode Selector

This block takes the signed actual velocity of a stepper motion controller and compares its magnitude against three programmable unsigned limits. The first is a lower limit above which load-adaptive current control and the stall-stop window are allowed. The second is a high-velocity limit above which the driver leaves quiet voltage-PWM operation and may switch to a constant-off-time chopper and to fullstepping. The third is a minimum velocity for automatic commutation. From these comparisons it produces six registered mode-enable flags for the driver. The chopper and commutation engines that act on these flags lie outside this block.

Each limit is 23 bits wide, but the comparisons use only bits 22:8 of the limit and of the velocity magnitude. A magnitude at or above 2^23 counts as larger than any limit. A commutation limit whose bits 22:8 are all zero (any value below 256, including 0) turns commutation off. Above an armed commutation limit the block triggers every high-velocity action as well. The stall-stop window sets when the magnitude reaches the lower limit. It clears when the magnitude drops below that limit, unless commutation is active in that cycle, in which case it holds its state.

Top module: `vtm_select`

## Requirements
- R1: Only bits 22:8 of each limit and of the velocity magnitude take part in the comparisons. With a lower limit of 0x1FF, a magnitude of 0x100 counts as reaching it and a magnitude of 0xFF does not. A magnitude of 2^23 or more counts as reaching every limit.
- R2: load_adapt_o is 1 exactly when the magnitude reaches the lower limit and no high-velocity condition holds.
- R3: quiet_ok_o is 1 exactly when the magnitude is below the lower limit and no high-velocity condition holds.
- R4: When the magnitude reaches the high limit, load_adapt_o is 0. cot_chop_o then equals cfg_hv_chop_i, and fullstep_o equals cfg_hv_fs_i. With no high-velocity condition, both are 0.
- R5: When bits 22:8 of thr_dc_i are zero, commut_o stays 0 whatever the velocity.
- R6: When the commutation limit is armed and the magnitude reaches it, commut_o is 1. All high-velocity actions of R2 to R4 then apply, even if the magnitude is below the high limit.
- R7: stall_win_o becomes 1 when the magnitude reaches the lower limit. Outside commutation it becomes 0 when the magnitude is below the lower limit.
- R8: While commutation is active and the magnitude is below the lower limit, stall_win_o keeps its previous value.
- R9: The magnitude of a negative velocity equals that of its positive counterpart. The most negative velocity 0x80000000 saturates to 0x7FFFFFFF and so reaches every limit.
- R10: Reset sets all six outputs to 0. Every output reflects the inputs present at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vel_i | input | 32 | Signed actual velocity (two's complement) |
| thr_lo_i | input | 23 | Lower limit for load-adaptive current and stall window |
| thr_hi_i | input | 23 | High-velocity limit |
| thr_dc_i | input | 23 | Minimum commutation velocity; below 256 means disabled |
| cfg_hv_chop_i | input | 1 | Request constant-off-time chopper at high velocity |
| cfg_hv_fs_i | input | 1 | Request fullstep at high velocity |
| load_adapt_o | output | 1 | Load-adaptive current control enabled |
| stall_win_o | output | 1 | Stop-on-stall window enabled |
| quiet_ok_o | output | 1 | Quiet voltage-PWM operation allowed |
| cot_chop_o | output | 1 | Constant-off-time slow-decay chopper selected |
| fullstep_o | output | 1 | Fullstep operation selected |
| commut_o | output | 1 | Automatic commutation mode enabled |

## Verification
The hardest case to reach is the stall window holding while the velocity is below the lower limit. That only happens when commutation is active, which needs a commutation limit below the lower limit and a velocity between the two. The stimulus first drives the velocity above the lower limit to set the window. It then drops the velocity into that gap and checks that the window stays set. Finally it disarms the commutation limit at the same velocity and checks that the window clears. The truncation boundary at bit 8 and the saturating most-negative velocity are also driven directly.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    localparam int VEL_W   = 32;
    localparam int THR_W   = 23;
    localparam int CMP_LSB = 8;
    localparam int CMP_W   = THR_W - CMP_LSB;
    localparam int N_THR   = 3;

    typedef enum int {
        THR_LO = 0,
        THR_HI = 1,
        THR_DC = 2
    } thr_idx_e;

    typedef struct packed {
        logic load_adapt;
        logic stall_win;
        logic quiet_ok;
        logic cot_chop;
        logic fullstep;
        logic commut;
    } mode_t;

    // Reduce an unsigned magnitude to the compared field, saturating wide values.
    function automatic logic [CMP_W-1:0] trim_mag(input logic [VEL_W-1:0] mag);
        if (|mag[VEL_W-1:THR_W])
            return {CMP_W{1'b1}};
        return mag[THR_W-1:CMP_LSB];
    endfunction
endpackage

// File: rtl/vtm_abs_sat.sv
module vtm_abs_sat
    import vtm_pkg::*;
(
    input  logic [VEL_W-1:0] vel_i,
    output logic [VEL_W-1:0] mag_o
);
    localparam logic [VEL_W-1:0] MOST_NEG = {1'b1, {(VEL_W-1){1'b0}}};
    localparam logic [VEL_W-1:0] MOST_POS = {1'b0, {(VEL_W-1){1'b1}}};

    always_comb begin
        if (vel_i == MOST_NEG)
            mag_o = MOST_POS;
        else if (vel_i[VEL_W-1])
            mag_o = ~vel_i + 1'b1;
        else
            mag_o = vel_i;
    end
endmodule

// File: rtl/vtm_thr_cmp.sv
module vtm_thr_cmp
    import vtm_pkg::*;
(
    input  logic [CMP_W-1:0] mag_t_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             reach_o,
    output logic             armed_o
);
    logic [CMP_W-1:0] thr_t;

    assign thr_t   = thr_i[THR_W-1:CMP_LSB];
    assign reach_o = (mag_t_i >= thr_t);
    assign armed_o = |thr_t;
endmodule

// File: rtl/vtm_mode_reg.sv
module vtm_mode_reg
    import vtm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  reach_lo_i,
    input  logic  reach_hi_i,
    input  logic  reach_dc_i,
    input  logic  dc_armed_i,
    input  logic  cfg_chop_i,
    input  logic  cfg_fs_i,
    output mode_t mode_o
);
    mode_t mode_d;
    mode_t mode_q;
    logic  dc_on;
    logic  high;

    always_comb begin
        dc_on = dc_armed_i && reach_dc_i;
        high  = reach_hi_i || dc_on;
        mode_d.load_adapt = reach_lo_i && !high;
        mode_d.quiet_ok   = !reach_lo_i && !high;
        mode_d.cot_chop   = high && cfg_chop_i;
        mode_d.fullstep   = high && cfg_fs_i;
        mode_d.commut     = dc_on;
        // Window sets on reaching the lower limit; commutation freezes it below.
        mode_d.stall_win  = reach_lo_i || (mode_q.stall_win && dc_on);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else
            mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/vtm_select.sv
module vtm_select
    import vtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VEL_W-1:0] vel_i,
    input  logic [THR_W-1:0] thr_lo_i,
    input  logic [THR_W-1:0] thr_hi_i,
    input  logic [THR_W-1:0] thr_dc_i,
    input  logic             cfg_hv_chop_i,
    input  logic             cfg_hv_fs_i,
    output logic             load_adapt_o,
    output logic             stall_win_o,
    output logic             quiet_ok_o,
    output logic             cot_chop_o,
    output logic             fullstep_o,
    output logic             commut_o
);
    logic [VEL_W-1:0] mag;
    logic [CMP_W-1:0] mag_t;
    logic [THR_W-1:0] thr_arr [N_THR];
    logic [N_THR-1:0] reach;
    logic [N_THR-1:0] armed;
    mode_t            mode;

    vtm_abs_sat u_abs (
        .vel_i (vel_i),
        .mag_o (mag)
    );

    assign mag_t = trim_mag(mag);

    assign thr_arr[THR_LO] = thr_lo_i;
    assign thr_arr[THR_HI] = thr_hi_i;
    assign thr_arr[THR_DC] = thr_dc_i;

    for (genvar gi = 0; gi < N_THR; gi++) begin : g_cmp
        vtm_thr_cmp u_cmp (
            .mag_t_i (mag_t),
            .thr_i   (thr_arr[gi]),
            .reach_o (reach[gi]),
            .armed_o (armed[gi])
        );
    end

    vtm_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .reach_lo_i (reach[THR_LO]),
        .reach_hi_i (reach[THR_HI]),
        .reach_dc_i (reach[THR_DC]),
        .dc_armed_i (armed[THR_DC]),
        .cfg_chop_i (cfg_hv_chop_i),
        .cfg_fs_i   (cfg_hv_fs_i),
        .mode_o     (mode)
    );

    assign load_adapt_o = mode.load_adapt;
    assign stall_win_o  = mode.stall_win;
    assign quiet_ok_o   = mode.quiet_ok;
    assign cot_chop_o   = mode.cot_chop;
    assign fullstep_o   = mode.fullstep;
    assign commut_o     = mode.commut;
endmodule

// File: rtl/vtm_select_chk.sv
module vtm_select_chk
    import vtm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [THR_W-1:0] thr_dc_i,
    input logic             cfg_hv_chop_i,
    input logic             cfg_hv_fs_i,
    input logic             load_adapt_o,
    input logic             stall_win_o,
    input logic             quiet_ok_o,
    input logic             cot_chop_o,
    input logic             fullstep_o,
    input logic             commut_o
);
    AST_QUIET_EXCL: assert property (@(posedge clk) disable iff (rst)
        quiet_ok_o |-> (!load_adapt_o && !stall_win_o && !commut_o)); // R3

    AST_LOAD_NOT_HIGH: assert property (@(posedge clk) disable iff (rst)
        load_adapt_o |-> (!cot_chop_o && !fullstep_o && !commut_o)); // R4

    AST_FS_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
        (fullstep_o && !$rose(fullstep_o)) |-> $past(cfg_hv_fs_i)); // R4

    AST_CHOP_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
        (cot_chop_o && !$rose(cot_chop_o)) |-> $past(cfg_hv_chop_i)); // R4

    AST_DC_DISARMED: assert property (@(posedge clk) disable iff (rst)
        (thr_dc_i[THR_W-1:CMP_LSB] == '0) |=> !commut_o); // R5

    AST_COMMUT_HIGH: assert property (@(posedge clk) disable iff (rst)
        commut_o |-> (!load_adapt_o && !quiet_ok_o)); // R6

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_win_o) |-> !commut_o); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !(load_adapt_o || stall_win_o || quiet_ok_o ||
                  cot_chop_o || fullstep_o || commut_o)); // R10
endmodule

bind vtm_select vtm_select_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .thr_dc_i      (thr_dc_i),
    .cfg_hv_chop_i (cfg_hv_chop_i),
    .cfg_hv_fs_i   (cfg_hv_fs_i),
    .load_adapt_o  (load_adapt_o),
    .stall_win_o   (stall_win_o),
    .quiet_ok_o    (quiet_ok_o),
    .cot_chop_o    (cot_chop_o),
    .fullstep_o    (fullstep_o),
    .commut_o      (commut_o)
);

// File: tb/vtm_select_test.sv
module vtm_select_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] vel_i = '0;
    logic [22:0] thr_lo_i = '0;
    logic [22:0] thr_hi_i = '0;
    logic [22:0] thr_dc_i = '0;
    logic        cfg_hv_chop_i = 1'b0;
    logic        cfg_hv_fs_i = 1'b0;
    logic        load_adapt_o, stall_win_o, quiet_ok_o, cot_chop_o, fullstep_o, commut_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    bit model_win = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];

    always #10 clk = ~clk;

    vtm_select uut (
        .clk(clk), .rst(rst), .vel_i(vel_i),
        .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i), .thr_dc_i(thr_dc_i),
        .cfg_hv_chop_i(cfg_hv_chop_i), .cfg_hv_fs_i(cfg_hv_fs_i),
        .load_adapt_o(load_adapt_o), .stall_win_o(stall_win_o),
        .quiet_ok_o(quiet_ok_o), .cot_chop_o(cot_chop_o),
        .fullstep_o(fullstep_o), .commut_o(commut_o)
    );

    // Output order: load_adapt, stall_win, quiet_ok, cot_chop, fullstep, commut
    function automatic logic [5:0] outs();
        return {load_adapt_o, stall_win_o, quiet_ok_o, cot_chop_o, fullstep_o, commut_o};
    endfunction

    function automatic longint field_of(longint m);
        if (m >= 64'd8388608) return 64'd32767;
        return m / 256;
    endfunction

    task automatic drive(input logic [31:0] v, input logic [22:0] lo, input logic [22:0] hi,
                         input logic [22:0] dc, input bit chop, input bit fs, input string tag);
        longint sv, mag, mt;
        bit rlo, rhi, rdc, dcon, high, win;
        item_t it;
        @(negedge clk);
        vel_i = v; thr_lo_i = lo; thr_hi_i = hi; thr_dc_i = dc;
        cfg_hv_chop_i = chop; cfg_hv_fs_i = fs;
        sv  = longint'($signed(v));
        mag = (sv < 0) ? -sv : sv;
        if (mag > 64'h7FFFFFFF) mag = 64'h7FFFFFFF;
        mt   = field_of(mag);
        rlo  = mt >= longint'(lo) / 256;
        rhi  = mt >= longint'(hi) / 256;
        rdc  = mt >= longint'(dc) / 256;
        dcon = (dc >= 23'd256) && rdc;
        high = rhi || dcon;
        win  = rlo || (model_win && dcon);
        model_win = win;
        it.exp = {rlo && !high, win, !rlo && !high, high && chop, high && fs, dcon};
        it.tag = tag;
        sbq.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                compared++;
                if (outs() !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: got %b expected %b", it.tag, outs(), it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        compared++;
        if (outs() !== 6'b0) begin
            mismatched++;
            $display("FAIL R10 reset: got %b expected %b", outs(), 6'b0);
        end
        rst = 1'b0;
        model_win = 1'b0;
        // R3: slow motion, quiet allowed
        drive(32'd100, 23'd1000, 23'd400000, 23'd0, 1'b1, 1'b1, "R3 quiet below lower");
        // R1: truncation boundary at bit 8
        drive(32'h100, 23'h1FF, 23'h7FFFFF, 23'd0, 1'b0, 1'b0, "R1 0x100 reaches 0x1FF");
        drive(32'hFF, 23'h1FF, 23'h7FFFFF, 23'd0, 1'b0, 1'b0, "R1 0xFF below 0x1FF");
        drive(32'd9000000, 23'h7FFFFF, 23'h7FFFFF, 23'd0, 1'b0, 1'b1, "R1 wide magnitude");
        // R2: window between limits, negative velocity
        drive(-32'sd30000, 23'd10000, 23'd400000, 23'd0, 1'b1, 1'b1, "R2 window negative");
        drive(32'd30000, 23'd10000, 23'd400000, 23'd0, 1'b1, 1'b1, "R2 window positive");
        // R4: above high limit with each config
        drive(32'd500000, 23'd10000, 23'd400000, 23'd0, 1'b1, 1'b0, "R4 high chop only");
        drive(32'd500000, 23'd10000, 23'd400000, 23'd0, 1'b0, 1'b1, "R4 high fullstep only");
        drive(-32'sd500000, 23'd10000, 23'd400000, 23'd0, 1'b0, 1'b0, "R4 high no config");
        // R5: commutation limit below floor
        drive(32'd500000, 23'd10000, 23'h7FFFFF, 23'd200, 1'b1, 1'b1, "R5 dc below 256");
        drive(32'd500000, 23'd10000, 23'h7FFFFF, 23'd0, 1'b1, 1'b1, "R5 dc zero");
        // R6: commutation triggers high actions under high limit
        drive(-32'sd350000, 23'd10000, 23'h7FFFFF, 23'd300000, 1'b1, 1'b1, "R6 commut high actions");
        // R7/R8: window hold in commutation gap
        drive(32'd1000, 23'd400000, 23'h7FFFFF, 23'd300000, 1'b0, 1'b0, "R7 window off low");
        drive(32'd500000, 23'd400000, 23'h7FFFFF, 23'd300000, 1'b0, 1'b0, "R7 window set");
        drive(32'd350000, 23'd400000, 23'h7FFFFF, 23'd300000, 1'b0, 1'b0, "R8 window held in commut");
        drive(32'd350000, 23'd400000, 23'h7FFFFF, 23'd300000, 1'b0, 1'b0, "R8 window still held");
        drive(32'd350000, 23'd400000, 23'h7FFFFF, 23'd0, 1'b0, 1'b0, "R7 window clears outside commut");
        drive(32'd350000, 23'd400000, 23'h7FFFFF, 23'd300000, 1'b0, 1'b0, "R8 commut does not set window");
        // R9: saturation of most negative value
        drive(32'h80000000, 23'd10000, 23'h7FFFFF, 23'd0, 1'b1, 1'b1, "R9 most negative saturates");
        drive(32'h7FFFFFFF, 23'd10000, 23'h7FFFFF, 23'd0, 1'b1, 1'b1, "R9 most positive");
        drive(-32'sd1000, 23'd1000, 23'd400000, 23'd0, 1'b0, 1'b0, "R9 symmetric magnitude");
        // R10: quick reversal, one-cycle latency
        drive(32'd10, 23'd1000, 23'd400000, 23'd0, 1'b0, 1'b0, "R10 latency back to quiet");
        drive(32'd900000, 23'd1000, 23'd400000, 23'd0, 1'b1, 1'b0, "R10 latency jump high");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule